// File: doc/BRIEF.md
# Field Merge and Bit-Test Execution Unit

This unit executes three instructions of a small 16-bit controller. The first rotates operand A, cuts a contiguous bit field out of it and merges that field into operand B, which yields a value for the destination register. The other two are conditional branches. Each forms a 32-bit word with B in the upper half and A in the lower half, masks a field of that word, and reports a taken branch when the field is zero or when it is non-zero.

A 12-bit opcode selects the operation. Its two low nibbles give a field-length code `M` (the field is `M+1` bits wide) and a position code `S`. The one mask generator serves both families. For the merge it rotates the mask within 16 bits. For the branches it shifts the mask into the 32-bit word without wrapping. When operand A comes from an immediate, only its low bits are used. An opcode outside the three families raises an illegal flag and has no other effect. All results are registered, so each one appears one cycle after it is presented and is marked by a valid strobe.

Top module: `fldx_unit`

## Requirements
- R1: Bits [11:8] of the opcode select the operation: 0x3 is the merge, 0x4 is branch-if-zero and 0x5 is branch-if-non-zero. Bits [7:4] hold `M` and bits [3:0] hold `S`.
- R2: For the merge, the mask is `M+1` ones starting at bit 0, rotated left by `S` within 16 bits with wrap-around. The result is `(rotl16(A,S) & mask) | (B & ~mask)`. With `M=0`, `S=8`, bit 0 of A lands at bit 8 and B is kept everywhere else.
- R3: When `a_is_imm` is high, bits [15:10] of A are ignored and treated as zero before the rotation. With `M=7`, `S=8`, A=0x12 and B=0x34, the result is 0x1234.
- R4: For branch-if-zero, `br_taken` is high when `{B,A} & (((1<<(M+1))-1) << S)` is zero. The mask is shifted without wrap, and bits shifted above bit 31 are dropped.
- R5: For branch-if-non-zero, `br_taken` is high when that same masked 32-bit value is non-zero. With `M=4`, `S=12`, the tested bits are 12 to 16, so the test spans both operands.
- R6: Any other value of opcode bits [11:8] sets `illegal`. In that cycle `wr_en` and `br_taken` stay low and `wr_data` is zero.
- R7: For a branch, `wr_en` is low and `wr_data` is zero. For the merge, `br_taken` is low. `wr_data` is zero in every cycle where `wr_en` is low.
- R8: Every output reflects the inputs of the previous clock cycle. `out_valid` follows `in_valid` by one cycle. When `out_valid` is low, `wr_en`, `br_taken`, `illegal` and `wr_data` are all zero.
- R9: While `rst_n` is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Opcode and operands are presented this cycle |
| opcode | input | 12 | Operation base [11:8], field length code [7:4], position code [3:0] |
| opnd_a | input | 16 | Operand A: the merge source, or the low half of the test word |
| opnd_b | input | 16 | Operand B: the merge background, or the high half of the test word |
| a_is_imm | input | 1 | Operand A is an immediate; only its low 10 bits are used |
| out_valid | output | 1 | A result from the previous cycle is present |
| wr_en | output | 1 | Write `wr_data` to the destination register |
| wr_data | output | 16 | Merge result |
| br_taken | output | 1 | The branch condition holds |
| illegal | output | 1 | The opcode base is not one of the three handled |

## Verification
The mask generator and the illegal-opcode detector act on the same opcode in the same cycle. An unknown base arrives with field codes that would build a valid mask. The bench therefore sends such opcodes with operands that would cause a write or a taken branch, and it requires `illegal` high while `wr_en`, `br_taken` and `wr_data` are all quiet. Merges and branches are also issued back to back without idle cycles. Each registered output is compared every cycle with the bench's own model, so a result from one operation cannot leak into the next one.

// File: rtl/fldx_pkg.sv
// Shared definitions for the field merge / bit-test unit.
// Assumes the opcode base occupies the top nibble of the opcode.
package fldx_pkg;
    localparam int BASE_W = 4;

    localparam logic [BASE_W-1:0] BASE_MERGE = 4'h3;
    localparam logic [BASE_W-1:0] BASE_JZ    = 4'h4;
    localparam logic [BASE_W-1:0] BASE_JNZ   = 4'h5;

    typedef enum logic [1:0] {
        FOP_NONE  = 2'd0,
        FOP_MERGE = 2'd1,
        FOP_JZ    = 2'd2,
        FOP_JNZ   = 2'd3
    } fldx_op_e;
endpackage

// File: rtl/fldx_decode.sv
// Opcode decoder: splits the opcode into an operation, a field length
// code and a position code. Assumes OPC_W = BASE_W + 2*FLD_W.
module fldx_decode
    import fldx_pkg::*;
#(
    parameter int FLD_W = 4,
    localparam int OPC_W = BASE_W + 2 * FLD_W
) (
    input  logic [OPC_W-1:0] opcode_i,
    output fldx_op_e         op_o,
    output logic [FLD_W-1:0] len_o,
    output logic [FLD_W-1:0] pos_o,
    output logic             bad_o
);
    logic [BASE_W-1:0] base;

    assign base  = opcode_i[OPC_W-1 -: BASE_W];
    assign len_o = opcode_i[2*FLD_W-1 -: FLD_W];
    assign pos_o = opcode_i[FLD_W-1:0];

    // Map the base nibble to an operation; unknown bases are flagged.
    always_comb begin
        bad_o = 1'b0;
        unique case (base)
            BASE_MERGE: op_o = FOP_MERGE;
            BASE_JZ:    op_o = FOP_JZ;
            BASE_JNZ:   op_o = FOP_JNZ;
            default: begin
                op_o  = FOP_NONE;
                bad_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/fldx_maskgen.sv
// Mask generator: builds a run of len+1 ones starting at bit 0. It gives
// that run rotated by pos within DATA_W bits (for the merge) and shifted
// by pos into a 2*DATA_W word without wrap (for the field test).
module fldx_maskgen #(
    parameter int DATA_W = 16,
    localparam int FLD_W = $clog2(DATA_W)
) (
    input  logic [FLD_W-1:0]    len_i,
    input  logic [FLD_W-1:0]    pos_i,
    output logic [DATA_W-1:0]   rot_mask_o,
    output logic [2*DATA_W-1:0] wide_mask_o
);
    logic [DATA_W-1:0]   run;
    logic [2*DATA_W-1:0] doubled;

    // One comparator per bit: bit i is set when i <= len.
    for (genvar i = 0; i < DATA_W; i++) begin : g_run
        assign run[i] = (32'(i) <= 32'(len_i));
    end

    // Rotate via the upper half of a shifted doubled copy.
    always_comb begin
        doubled    = {run, run} << pos_i;
        rot_mask_o = doubled[2*DATA_W-1:DATA_W];
    end

    // Shift without wrap into the double-width test word.
    assign wide_mask_o = {{DATA_W{1'b0}}, run} << pos_i;
endmodule

// File: rtl/fldx_merge.sv
// Merge datapath: rotates operand A left by pos and inserts it under the
// rotated mask into operand B. An immediate A keeps only its IMM_W low bits.
module fldx_merge #(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 10,
    localparam int FLD_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              a_imm_i,
    input  logic [FLD_W-1:0]  pos_i,
    input  logic [DATA_W-1:0] mask_i,
    output logic [DATA_W-1:0] res_o
);
    localparam logic [DATA_W-1:0] IMM_KEEP =
        {{(DATA_W-IMM_W){1'b0}}, {IMM_W{1'b1}}};

    logic [DATA_W-1:0]   a_eff;
    logic [2*DATA_W-1:0] a_dbl;
    logic [DATA_W-1:0]   a_rot;

    // Trim the immediate, rotate it, then select between the two sources.
    always_comb begin
        a_eff = a_imm_i ? (a_i & IMM_KEEP) : a_i;
        a_dbl = {a_eff, a_eff} << pos_i;
        a_rot = a_dbl[2*DATA_W-1:DATA_W];
        res_o = (a_rot & mask_i) | (b_i & ~mask_i);
    end
endmodule

// File: rtl/fldx_test.sv
// Field test: masks the word {B, A} and decides whether a zero or a
// non-zero test branch is taken. Non-branch operations never report taken.
module fldx_test
    import fldx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0]   a_i,
    input  logic [DATA_W-1:0]   b_i,
    input  logic [2*DATA_W-1:0] mask_i,
    input  fldx_op_e            op_i,
    output logic                taken_o
);
    logic field_zero;

    assign field_zero = ~|({b_i, a_i} & mask_i);

    // Pick the sense of the test from the operation.
    always_comb begin
        unique case (op_i)
            FOP_JZ:  taken_o = field_zero;
            FOP_JNZ: taken_o = ~field_zero;
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fldx_unit.sv
// Top of the field merge / bit-test unit. Decode, mask generation, merge
// and field test are combinational; a single register stage drives all
// outputs, one cycle after in_valid. Synchronous active-low reset.
module fldx_unit
    import fldx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 10,
    localparam int FLD_W = $clog2(DATA_W),
    localparam int OPC_W = BASE_W + 2 * FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              a_is_imm,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              br_taken,
    output logic              illegal
);
    fldx_op_e            op;
    logic [FLD_W-1:0]    len;
    logic [FLD_W-1:0]    pos;
    logic                bad;
    logic [DATA_W-1:0]   rot_mask;
    logic [2*DATA_W-1:0] wide_mask;
    logic [DATA_W-1:0]   merged;
    logic                taken;

    fldx_decode #(.FLD_W(FLD_W)) u_dec (
        .opcode_i (opcode),
        .op_o     (op),
        .len_o    (len),
        .pos_o    (pos),
        .bad_o    (bad)
    );

    fldx_maskgen #(.DATA_W(DATA_W)) u_mask (
        .len_i       (len),
        .pos_i       (pos),
        .rot_mask_o  (rot_mask),
        .wide_mask_o (wide_mask)
    );

    fldx_merge #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_merge (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .a_imm_i (a_is_imm),
        .pos_i   (pos),
        .mask_i  (rot_mask),
        .res_o   (merged)
    );

    fldx_test #(.DATA_W(DATA_W)) u_test (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .mask_i  (wide_mask),
        .op_i    (op),
        .taken_o (taken)
    );

    // Output stage: qualify every result with in_valid and register it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            br_taken  <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid && (op == FOP_MERGE);
            wr_data   <= (in_valid && (op == FOP_MERGE)) ? merged : '0;
            br_taken  <= in_valid && taken;
            illegal   <= in_valid && bad;
        end
    end
endmodule

// File: rtl/fldx_checker.sv
// Port-level properties of the field merge / bit-test unit, attached to
// every instance of the top by the bind below.
module fldx_checker #(
    parameter int DATA_W = 16,
    localparam int OPC_W = 4 + 2 * $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  opcode,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              out_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              br_taken,
    input logic              illegal
);
    logic [3:0] base;
    assign base = opcode[OPC_W-1 -: 4];

    p_merge_writes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && base == 4'h3 |=> wr_en && !br_taken && !illegal);

    p_branch_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (base == 4'h4 || base == 4'h5) |=> !wr_en && wr_data == '0);

    p_zero_word_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && base == 4'h4 && opnd_a == '0 && opnd_b == '0 |=> br_taken);

    p_zero_word_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && base == 4'h5 && opnd_a == '0 && opnd_b == '0 |=> !br_taken);

    p_illegal_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en && !br_taken && wr_data == '0);

    p_data_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> wr_data == '0);

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en && !br_taken && !illegal);

    p_one_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, br_taken, illegal}));
endmodule

bind fldx_unit fldx_checker #(.DATA_W(DATA_W)) u_fldx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opcode    (opcode),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .br_taken  (br_taken),
    .illegal   (illegal)
);

// File: tb/fldx_unit_tb.sv
module fldx_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] opcode = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic        a_is_imm = 1'b0;
    logic        out_valid, wr_en, br_taken, illegal;
    logic [15:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fldx_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .a_is_imm(a_is_imm),
        .out_valid(out_valid), .wr_en(wr_en), .wr_data(wr_data),
        .br_taken(br_taken), .illegal(illegal)
    );

    // Reference: merge computed bit by bit from the requirement text.
    function automatic logic [15:0] ref_merge(logic [3:0] m, logic [3:0] s,
                                              logic [15:0] a, logic [15:0] b, logic imm);
        logic [15:0] aa = imm ? (a & 16'h03FF) : a;
        logic [15:0] mk = '0;
        logic [15:0] ar = '0;
        for (int i = 0; i < 16; i++) begin
            if (i <= int'(m)) mk[(i + int'(s)) % 16] = 1'b1;
            ar[(i + int'(s)) % 16] = aa[i];
        end
        return (ar & mk) | (b & ~mk);
    endfunction

    // Reference: zero test of the masked 32-bit word {b, a}.
    function automatic logic ref_zero(logic [3:0] m, logic [3:0] s,
                                      logic [15:0] a, logic [15:0] b);
        logic [31:0] w = {b, a};
        logic z = 1'b1;
        for (int i = 0; i <= int'(m); i++)
            if (i + int'(s) < 32 && w[i + int'(s)]) z = 1'b0;
        return z;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Present one operation at a negedge and check it at the next negedge.
    task automatic run_op(string tag, logic [11:0] opc, logic [15:0] a,
                          logic [15:0] b, logic imm);
        logic [3:0] base = opc[11:8];
        logic [3:0] m = opc[7:4];
        logic [3:0] s = opc[3:0];
        logic e_wr = (base == 4'h3);
        logic e_br = (base == 4'h4 && ref_zero(m, s, a, b)) ||
                     (base == 4'h5 && !ref_zero(m, s, a, b));
        logic e_bad = !(base inside {4'h3, 4'h4, 4'h5});
        logic [15:0] e_dat = e_wr ? ref_merge(m, s, a, b, imm) : 16'h0;
        in_valid = 1'b1; opcode = opc; opnd_a = a; opnd_b = b; a_is_imm = imm;
        @(negedge clk);
        chk({tag, " R8 valid"}, 16'(out_valid), 16'h1);
        chk({tag, " R7 wr_en"}, 16'(wr_en), 16'(e_wr));
        chk({tag, " wr_data"}, wr_data, e_dat);
        chk({tag, " br_taken"}, 16'(br_taken), 16'(e_br));
        chk({tag, " R6 illegal"}, 16'(illegal), 16'(e_bad));
    endtask

    task automatic idle_cycle();
        in_valid = 1'b0; opcode = 12'h3FF; opnd_a = 16'hFFFF; opnd_b = 16'hFFFF;
        @(negedge clk);
        chk("R8 idle valid", 16'(out_valid), 16'h0);
        chk("R8 idle quiet", {13'h0, wr_en, br_taken, illegal}, 16'h0);
        chk("R8 idle data", wr_data, 16'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd13579));
        in_valid = 1'b1; opcode = 12'h378; opnd_a = 16'h0012; opnd_b = 16'h0034;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", 16'(out_valid), 16'h0);
        chk("R9 reset flags", {13'h0, wr_en, br_taken, illegal}, 16'h0);
        chk("R9 reset data", wr_data, 16'h0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // Directed merge cases.
        run_op("R2 single bit", 12'h308, 16'h0001, 16'h0000, 1'b0);
        chk("R2 bit0 to bit8", wr_data, 16'h0100);
        run_op("R2 keep B", 12'h308, 16'hFFFE, 16'hFFFF, 1'b0);
        chk("R2 keep B value", wr_data, 16'hFEFF);
        run_op("R3 load", 12'h378, 16'h0012, 16'h0034, 1'b1);
        chk("R3 load value", wr_data, 16'h1234);
        run_op("R2 wrap", 12'h37C, 16'h00AB, 16'h1234, 1'b0);
        chk("R2 wrap value", wr_data, 16'hB23A);
        run_op("R3 imm trim", 12'h3F0, 16'hFC01, 16'h0000, 1'b1);
        chk("R3 trimmed", wr_data, 16'h0001);
        run_op("R2 full reg", 12'h3F0, 16'hFC01, 16'h0000, 1'b0);
        chk("R2 untrimmed", wr_data, 16'hFC01);

        // Directed branch cases across the operand boundary.
        run_op("R5 low half", 12'h54C, 16'h1000, 16'h0000, 1'b0);
        chk("R5 taken", 16'(br_taken), 16'h1);
        run_op("R5 high half", 12'h54C, 16'h0000, 16'h0001, 1'b0);
        chk("R5 taken hi", 16'(br_taken), 16'h1);
        run_op("R4 outside", 12'h44C, 16'h0FFF, 16'hFFFE, 1'b0);
        chk("R4 taken", 16'(br_taken), 16'h1);
        run_op("R4 inside", 12'h44C, 16'h0000, 16'h0001, 1'b0);
        chk("R4 not taken", 16'(br_taken), 16'h0);
        run_op("R4 no wrap", 12'h4FF, 16'h7FFF, 16'h8000, 1'b0);
        chk("R4 top bit dropped", 16'(br_taken), 16'h1);

        // Illegal bases carrying field codes that would otherwise act.
        run_op("R6 base6", 12'h678, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op("R6 base0", 12'h0FF, 16'hFFFF, 16'h0000, 1'b0);
        run_op("R6 baseF", 12'hF00, 16'h0001, 16'h0001, 1'b1);
        idle_cycle();

        // Constrained random, back to back, with occasional idle cycles.
        for (int n = 0; n < 400; n++) begin
            int sel = int'($urandom % 8);
            logic [3:0] base;
            if (sel < 3) base = 4'h3;
            else if (sel < 5) base = 4'h4;
            else if (sel < 7) base = 4'h5;
            else begin
                base = 4'($urandom);
                if (base inside {4'h3, 4'h4, 4'h5}) base = 4'h9;
            end
            run_op("R1 random", {base, 8'($urandom)}, 16'($urandom),
                   16'($urandom), 1'($urandom));
            if (($urandom % 16) == 0) idle_cycle();
        end
        idle_cycle();

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule